// File: doc/BRIEF.md
# Dual-Port Bit-Wide Lookup-Table RAM

This block is a one-bit-wide random-access memory organised the way a lookup-table fabric organises it. Storage comes in 16-entry banks addressed by four bits. A deeper array of 32 entries uses two banks. The highest address bit picks which bank takes a write, and it drives a 2:1 selector on each read path.

Port A is the write/read port. On a rising `wclk` edge with `wr_en` high, it stores `wr_bit` at `addr_a`. Its output `rd_a` always shows the word at `addr_a`. Port B is read-only: its output `rd_b` shows the word at its own address `addr_b`. Both ports read combinationally.

A parameter can add a capture register behind both outputs. This register is clocked by `wclk`, gated by `out_ce`, and has no reset, which gives a synchronous read. Wider words are built by placing several copies side by side.

Top module: `lutram_dp`

## Requirements
- R1: Parameter `DEPTH` is 16 or 32, and the address width is 4 or 5 bits to match. A 16-deep instance behaves like a single bank on its four address bits.
- R2: With `DEPTH`=32, address bit 4 selects the bank (0 = lower, 1 = upper). Two addresses that differ only in bit 4 hold independent words.
- R3: On a rising `wclk` edge with `wr_en`=1, the word at `addr_a` takes the value of `wr_bit`.
- R4: On a rising `wclk` edge with `wr_en`=0, no stored word changes.
- R5: With `OUT_REG`=0, `rd_a` shows the word at `addr_a` combinationally. It follows a change of `addr_a` with no clock edge.
- R6: With `OUT_REG`=0, `rd_b` shows the word at `addr_b` combinationally, and a port-A write is seen on `rd_b` whenever `addr_b` equals the written address.
- R7: When `addr_b` equals `addr_a` during a write, both outputs show the old value before the edge and the new value after it.
- R8: With `OUT_REG`=1, on a rising `wclk` edge with `out_ce`=1, `rd_a` and `rd_b` take the values the combinational reads had just before that edge. With `out_ce`=0 they hold.
- R9: All words read as 0 before any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock, also clocks the optional output register |
| wr_en | input | 1 | Write enable for port A |
| addr_a | input | AW | Port A address (write and read) |
| wr_bit | input | 1 | Data written at `addr_a` |
| addr_b | input | AW | Port B read address |
| out_ce | input | 1 | Clock enable of the optional output register |
| rd_a | output | 1 | Port A read data |
| rd_b | output | 1 | Port B read data |

## Verification
The hardest case to reach is a collision: a write lands while port B reads the same address, and the bank select must keep the two halves apart. Random traffic rarely produces this on its own. Directed steps therefore set `addr_b` equal to `addr_a` during writes and check both outputs just before and just after the edge. Another directed step writes one address and reads its partner, which differs only in bit 4. Random traffic then compares a 32-deep, a 16-deep and a registered instance against a behavioural array on every cycle.

// File: rtl/lutram_pkg.sv
package lutram_pkg;
   localparam int BANK_AW    = 4;
   localparam int BANK_DEPTH = 1 << BANK_AW;

   function automatic int bank_count(input int depth);
      return (depth + BANK_DEPTH - 1) / BANK_DEPTH;
   endfunction
endpackage

// File: rtl/lutram_bank.sv
module lutram_bank #(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic          din,
   input  logic [AW-1:0] rb,
   output logic          qa,
   output logic          qb
);
   localparam int N = 1 << AW;

   logic [N-1:0] cells = '0;

   always_ff @(posedge clk) begin
      if (we) cells[wa] <= din;
   end

   assign qa = cells[wa];
   assign qb = cells[rb];
endmodule

// File: rtl/lutram_oreg.sv
module lutram_oreg #(
   parameter bit EN = 1'b0,
   parameter int W  = 2
) (
   input  logic         clk,
   input  logic         ce,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (EN) begin : g_reg
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (ce) q <= din;
         end
         assign dout = q;
      end else begin : g_pass
         logic unused_clk_ce;
         assign unused_clk_ce = clk ^ ce;
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/lutram_dp.sv
module lutram_dp
   import lutram_pkg::*;
#(
   parameter int DEPTH   = 32,
   parameter bit OUT_REG = 1'b0,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          wr_en,
   input  logic [AW-1:0] addr_a,
   input  logic          wr_bit,
   input  logic [AW-1:0] addr_b,
   input  logic          out_ce,
   output logic          rd_a,
   output logic          rd_b
);
   localparam int NB = bank_count(DEPTH);
   localparam int SW = (AW > BANK_AW) ? AW - BANK_AW : 1;

   logic [NB-1:0] bank_we;
   logic [NB-1:0] bank_qa;
   logic [NB-1:0] bank_qb;
   logic          raw_a;
   logic          raw_b;
   logic [1:0]    reg_out;

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         if (NB == 1) begin : g_one
            assign bank_we[b] = wr_en;
         end else begin : g_sel
            assign bank_we[b] = wr_en && (addr_a[AW-1:BANK_AW] == SW'(b));
         end
         lutram_bank #(.AW(BANK_AW)) u_bank (
            .clk (wclk),
            .we  (bank_we[b]),
            .wa  (addr_a[BANK_AW-1:0]),
            .din (wr_bit),
            .rb  (addr_b[BANK_AW-1:0]),
            .qa  (bank_qa[b]),
            .qb  (bank_qb[b])
         );
      end

      if (NB == 1) begin : g_nomux
         assign raw_a = bank_qa[0];
         assign raw_b = bank_qb[0];
      end else begin : g_mux
         assign raw_a = bank_qa[addr_a[AW-1:BANK_AW]];
         assign raw_b = bank_qb[addr_b[AW-1:BANK_AW]];
      end
   endgenerate

   lutram_oreg #(.EN(OUT_REG), .W(2)) u_oreg (
      .clk  (wclk),
      .ce   (out_ce),
      .din  ({raw_b, raw_a}),
      .dout (reg_out)
   );

   assign rd_a = reg_out[0];
   assign rd_b = reg_out[1];
endmodule

module lutram_dp_chk #(
   parameter int DEPTH   = 32,
   parameter bit OUT_REG = 1'b0,
   localparam int AW     = $clog2(DEPTH)
) (
   input logic          wclk,
   input logic          wr_en,
   input logic [AW-1:0] addr_a,
   input logic          wr_bit,
   input logic [AW-1:0] addr_b,
   input logic          out_ce,
   input logic          rd_a,
   input logic          rd_b
);
   logic past_ok = 1'b0;
   always_ff @(posedge wclk) past_ok <= 1'b1;

   // R1: legal depth
   initial begin
      a_r1_depth_legal: assert (DEPTH == 16 || DEPTH == 32)
         else $error("DEPTH must be 16 or 32");
   end

   generate
      if (!OUT_REG) begin : g_async
         a_r3_write_lands: assert property (@(posedge wclk) disable iff (!past_ok)
            ($past(wr_en) && addr_a == $past(addr_a)) |-> rd_a == $past(wr_bit));
         a_r6_write_seen_b: assert property (@(posedge wclk) disable iff (!past_ok)
            ($past(wr_en) && addr_b == $past(addr_a)) |-> rd_b == $past(wr_bit));
         a_r4_hold_no_write: assert property (@(posedge wclk) disable iff (!past_ok)
            (!$past(wr_en) && $stable(addr_a)) |-> $stable(rd_a));
         a_r5_ports_agree: assert property (@(posedge wclk) disable iff (!past_ok)
            (addr_a == addr_b) |-> rd_a == rd_b);
      end else begin : g_sync
         a_r8_hold_ce_low: assert property (@(posedge wclk) disable iff (!past_ok)
            !out_ce |=> ($stable(rd_a) && $stable(rd_b)));
         a_r8_ports_agree: assert property (@(posedge wclk) disable iff (!past_ok)
            (out_ce && addr_a == addr_b) |=> rd_a == rd_b);
      end
   endgenerate
endmodule

bind lutram_dp lutram_dp_chk #(.DEPTH(DEPTH), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tb_lutram_dp.sv
`timescale 1ns/100ps
module tb_lutram_dp;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       we = 1'b0, d = 1'b0, oce = 1'b0;
   logic [4:0] a = '0, ra = '0;
   logic spo0, dpo0, spor, dpor, spo16, dpo16;

   lutram_dp #(.DEPTH(32), .OUT_REG(1'b0)) dut (
      .wclk(clk), .wr_en(we), .addr_a(a), .wr_bit(d), .addr_b(ra), .out_ce(oce),
      .rd_a(spo0), .rd_b(dpo0));
   lutram_dp #(.DEPTH(32), .OUT_REG(1'b1)) dut_reg (
      .wclk(clk), .wr_en(we), .addr_a(a), .wr_bit(d), .addr_b(ra), .out_ce(oce),
      .rd_a(spor), .rd_b(dpor));
   lutram_dp #(.DEPTH(16), .OUT_REG(1'b0)) dut16 (
      .wclk(clk), .wr_en(we), .addr_a(a[3:0]), .wr_bit(d), .addr_b(ra[3:0]), .out_ce(oce),
      .rd_a(spo16), .rd_b(dpo16));

   bit ref32 [32];
   bit ref16 [16];
   bit ev_a, ev_b, reg_valid;
   int checks = 0, fails = 0;

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic step(input bit w, input bit [4:0] aa, input bit dd,
                       input bit [4:0] rr, input bit ce);
      string tw;
      @(negedge clk);
      we = w; a = aa; d = dd; ra = rr; oce = ce;
      #1;
      tw = (w && aa == rr) ? "R7" : "R5";
      chk(tw, spo0, ref32[aa]);
      chk((w && aa == rr) ? "R7" : "R6", dpo0, ref32[rr]);
      chk("R1", spo16, ref16[aa[3:0]]);
      chk("R1", dpo16, ref16[rr[3:0]]);
      if (ce) begin
         ev_a = ref32[aa]; ev_b = ref32[rr]; reg_valid = 1'b1;
      end
      if (w) begin
         ref32[aa] = dd; ref16[aa[3:0]] = dd;
      end
      @(posedge clk);
      #1;
      chk(w ? ((aa == rr) ? "R7" : "R3") : "R4", spo0, ref32[aa]);
      chk(w ? "R6" : "R4", dpo0, ref32[rr]);
      chk("R1", spo16, ref16[aa[3:0]]);
      chk("R1", dpo16, ref16[rr[3:0]]);
      if (reg_valid) begin
         chk("R8", spor, ev_a);
         chk("R8", dpor, ev_b);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R9: power-up contents are zero
      for (int i = 0; i < 32; i++) begin
         step(1'b0, 5'(i), 1'b0, 5'(31 - i), 1'b1);
         chk("R9", spo0, 1'b0);
         chk("R9", dpo0, 1'b0);
      end
      // R2: bit 4 separates banks
      step(1'b1, 5'd5, 1'b1, 5'd21, 1'b1);
      chk("R2", spo0, 1'b1);
      chk("R2", dpo0, 1'b0);
      step(1'b1, 5'd21, 1'b0, 5'd5, 1'b1);
      chk("R2", dpo0, 1'b1);
      step(1'b1, 5'd26, 1'b1, 5'd10, 1'b0);
      chk("R2", dpo0, 1'b0);
      // R7: collision, old value then new value
      step(1'b1, 5'd9, 1'b1, 5'd9, 1'b1);
      step(1'b1, 5'd9, 1'b0, 5'd9, 1'b1);
      step(1'b1, 5'd30, 1'b1, 5'd30, 1'b0);
      // R4: write enable low leaves contents untouched
      step(1'b0, 5'd5, 1'b0, 5'd5, 1'b1);
      chk("R4", spo0, 1'b1);
      // R8: out_ce low holds the register
      step(1'b1, 5'd12, 1'b1, 5'd12, 1'b0);
      step(1'b0, 5'd12, 1'b0, 5'd12, 1'b0);
      chk("R8", spor, ev_a);
      // random traffic on both ports
      for (int i = 0; i < 800; i++) begin
         bit [4:0] ax, bx;
         ax = 5'($urandom_range(0, 31));
         bx = ($urandom_range(0, 3) == 0) ? ax : 5'($urandom_range(0, 31));
         step(1'($urandom), ax, 1'($urandom), bx, 1'($urandom));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule